// File: doc/BRIEF.md
# Memory Access Permission Checker

The checker judges a single data access before the pipeline commits it. Each access comes with a one-cycle request strobe. The strobe carries the processor's control word, the alignment-check status flag, the current privilege level, the mode indications, the access address, size and direction, and the two attribute bits of the page being touched. The checker works out whether the access breaks the alignment rule or the page permission rule. One cycle later it reports a verdict with a two-bit fault code and one flag for each fault kind.

Alignment checking is armed only when four conditions hold together:

- the mask bit in the control word is set;
- the status flag is set;
- the access runs at user privilege (level 3);
- the processor is in protected or virtual-8086 mode.

Page permission follows the privilege level. User code may never touch a supervisor page and may never write a read-only page. Supervisor code may write a read-only page unless the write-protect bit in the control word is set.

The verdict register is a four-state machine:

- `ST_QUIET`: no verdict this cycle.
- `ST_PASS`: the access is allowed.
- `ST_ALIGN_FLT`: alignment fault.
- `ST_PROT_FLT`: protection fault.

The transitions are as follows. On every clock edge with the strobe high, the machine moves to the state named by the present judgement (`judge_pass`, `judge_align`, `judge_prot`). On every edge with the strobe low, it moves to `ST_QUIET` (`go_quiet`). Reset enters `ST_QUIET`.

Top module: `acc_guard`

## Requirements
- R1: An alignment fault is raised only when control word bit 18 is 1, the alignment-check flag is 1, the privilege level is 3, protected or virtual-8086 mode is indicated, and the access is misaligned.
- R2: With control word bit 18 at 0, no alignment fault is ever reported, whatever the other inputs are.
- R3: Size encoding is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes. An access is misaligned when its address bits below log2(size) are not all zero. One-byte accesses are never misaligned.
- R4: With control word bit 16 at 1, a write at privilege 0 to 2 to a page whose writable bit is 0 gives a protection fault.
- R5: With control word bit 16 at 0, a write at privilege 0 to 2 to a read-only page is allowed, whatever the page user bit is. Reads at privilege 0 to 2 never give a protection fault.
- R6: At privilege 3, an access to a page whose user bit is 0 faults, and a write to a page whose writable bit is 0 faults, whatever control word bit 16 is.
- R7: Fault code 2'b00 means none, 2'b01 alignment and 2'b10 protection. When both faults apply, the protection code is reported and the alignment flag stays 0.
- R8: The verdict appears on the outputs in the cycle after the clock edge that samples the strobe. After an edge with the strobe low, `verdict_valid` is 0, the code is 2'b00 and both flags are 0.
- R9: After reset, `verdict_valid`, both fault flags and the fault code are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| ctrl_word | input | 32 | Processor control word; bit 18 arms alignment checks, bit 16 is write protect |
| flag_align_chk | input | 1 | Alignment-check flag from the status register |
| cur_priv | input | 2 | Current privilege level, 3 is user |
| prot_mode | input | 1 | Protected mode indication |
| v86_mode | input | 1 | Virtual-8086 mode indication |
| acc_addr | input | AW | Access address |
| acc_size | input | 2 | Access size code |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| page_writable | input | 1 | Page read/write attribute, 1 is writable |
| page_user | input | 1 | Page user/supervisor attribute, 1 is user |
| verdict_valid | output | 1 | A verdict is presented this cycle |
| fault_align | output | 1 | Alignment fault verdict |
| fault_prot | output | 1 | Protection fault verdict |
| fault_code | output | 2 | Encoded fault |

## Verification
Every result of this block is due exactly one clock edge after the access is presented. The verdict code, both flags and the valid bit all come from the one state register, so none of them needs a different latency. The driver applies inputs on the falling edge and queues one expected entry for every cycle, including idle cycles that expect the quiet verdict. The monitor takes one entry 2 ns after each rising edge, so every comparison lands on the cycle that the single register stage makes visible.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

    typedef enum logic [1:0] {
        FC_NONE  = 2'b00,
        FC_ALIGN = 2'b01,
        FC_PROT  = 2'b10
    } fault_code_e;

    typedef enum logic [1:0] {
        ST_QUIET     = 2'd0,
        ST_PASS      = 2'd1,
        ST_ALIGN_FLT = 2'd2,
        ST_PROT_FLT  = 2'd3
    } verdict_state_e;

    localparam int CTRL_W       = 32;
    localparam int ALIGN_EN_BIT = 18;
    localparam int WR_PROT_BIT  = 16;
    localparam int SIZE_CODES   = 4;
    localparam logic [1:0] USER_PRIV = 2'd3;

endpackage

// File: rtl/acc_misalign.sv
module acc_misalign #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output logic          misaligned
);
    import acc_guard_pkg::*;

    logic [SIZE_CODES-1:0] size_hit;

    generate
        for (genvar s = 0; s < SIZE_CODES; s++) begin : g_size
            if (s == 0) begin : g_byte
                assign size_hit[s] = 1'b0;
            end else begin : g_wide
                assign size_hit[s] = |addr[s-1:0];
            end
        end
    endgenerate

    assign misaligned = size_hit[size];

    logic unused_addr_hi;
    assign unused_addr_hi = ^addr[AW-1:SIZE_CODES-1];

endmodule

// File: rtl/acc_page_judge.sv
module acc_page_judge (
    input  logic [1:0] priv,
    input  logic       wr_protect,
    input  logic       is_write,
    input  logic       writable,
    input  logic       user_page,
    output logic       prot_fault
);
    import acc_guard_pkg::*;

    logic is_user;
    logic user_bad;
    logic super_bad;

    always_comb begin
        is_user    = (priv == USER_PRIV);
        user_bad   = is_user && (!user_page || (is_write && !writable));
        super_bad  = !is_user && wr_protect && is_write && !writable;
        prot_fault = user_bad || super_bad;
    end

endmodule

// File: rtl/acc_verdict_fsm.sv
module acc_verdict_fsm (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    input  logic       align_bad,
    input  logic       prot_bad,
    output logic       verdict_valid,
    output logic       fault_align,
    output logic       fault_prot,
    output logic [1:0] fault_code
);
    import acc_guard_pkg::*;

    verdict_state_e state_q, state_d;

    always_comb begin
        state_d = ST_QUIET;
        if (strobe) begin
            if (prot_bad)       state_d = ST_PROT_FLT;
            else if (align_bad) state_d = ST_ALIGN_FLT;
            else                state_d = ST_PASS;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        verdict_valid = 1'b0;
        fault_align   = 1'b0;
        fault_prot    = 1'b0;
        fault_code    = FC_NONE;
        unique case (state_q)
            ST_QUIET: ;
            ST_PASS: verdict_valid = 1'b1;
            ST_ALIGN_FLT: begin
                verdict_valid = 1'b1;
                fault_align   = 1'b1;
                fault_code    = FC_ALIGN;
            end
            ST_PROT_FLT: begin
                verdict_valid = 1'b1;
                fault_prot    = 1'b1;
                fault_code    = FC_PROT;
            end
        endcase
    end

    assert_prot_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe && prot_bad |=> fault_prot && !fault_align);
    assert_quiet_after_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !verdict_valid && fault_code == 2'b00);
    assert_code_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault_code) && !(fault_align && fault_prot));

endmodule

// File: rtl/acc_guard.sv
module acc_guard #(
    parameter int AW = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic [acc_guard_pkg::CTRL_W-1:0] ctrl_word,
    input  logic                             flag_align_chk,
    input  logic [1:0]                       cur_priv,
    input  logic                             prot_mode,
    input  logic                             v86_mode,
    input  logic [AW-1:0]                    acc_addr,
    input  logic [1:0]                       acc_size,
    input  logic                             acc_write,
    input  logic                             page_writable,
    input  logic                             page_user,
    output logic                             verdict_valid,
    output logic                             fault_align,
    output logic                             fault_prot,
    output logic [1:0]                       fault_code
);
    import acc_guard_pkg::*;

    logic align_armed;
    logic misaligned;
    logic align_bad;
    logic prot_bad;

    assign align_armed = ctrl_word[ALIGN_EN_BIT] && flag_align_chk &&
                         (cur_priv == USER_PRIV) && (prot_mode || v86_mode);
    assign align_bad   = align_armed && misaligned;

    acc_misalign #(.AW(AW)) u_misalign (
        .addr       (acc_addr),
        .size       (acc_size),
        .misaligned (misaligned)
    );

    acc_page_judge u_judge (
        .priv       (cur_priv),
        .wr_protect (ctrl_word[WR_PROT_BIT]),
        .is_write   (acc_write),
        .writable   (page_writable),
        .user_page  (page_user),
        .prot_fault (prot_bad)
    );

    acc_verdict_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .strobe        (req_valid),
        .align_bad     (align_bad),
        .prot_bad      (prot_bad),
        .verdict_valid (verdict_valid),
        .fault_align   (fault_align),
        .fault_prot    (fault_prot),
        .fault_code    (fault_code)
    );

    logic unused_ctrl;
    assign unused_ctrl = ^ctrl_word;

    assert_no_align_when_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !ctrl_word[ALIGN_EN_BIT] |=> !fault_align);
    assert_align_needs_user_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_priv != USER_PRIV |=> !fault_align);
    assert_user_super_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_priv == USER_PRIV && !page_user |=> fault_prot);
    assert_super_read_ok_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_priv != USER_PRIV && !acc_write |=> !fault_prot);
    assert_strobe_gives_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> verdict_valid);

endmodule

// File: tb/acc_guard_test.sv
module acc_guard_test;

    localparam int AW = 32;

    typedef struct {
        logic       vld;
        logic [1:0] code;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic flag_align_chk = 1'b0;
    logic [1:0] cur_priv = '0;
    logic prot_mode = 1'b0;
    logic v86_mode = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0] acc_size = '0;
    logic acc_write = 1'b0;
    logic page_writable = 1'b0;
    logic page_user = 1'b0;
    logic verdict_valid, fault_align, fault_prot;
    logic [1:0] fault_code;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    exp_t sb[$];

    always #5 clk = ~clk;

    acc_guard #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ctrl_word(ctrl_word),
        .flag_align_chk(flag_align_chk), .cur_priv(cur_priv), .prot_mode(prot_mode),
        .v86_mode(v86_mode), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_write(acc_write), .page_writable(page_writable), .page_user(page_user),
        .verdict_valid(verdict_valid), .fault_align(fault_align),
        .fault_prot(fault_prot), .fault_code(fault_code)
    );

    function automatic logic [1:0] model(input logic am, input logic wp, input logic ac,
            input logic [1:0] pl, input logic pm, input logic vm, input logic [2:0] lo,
            input logic [1:0] sz, input logic wr, input logic rw, input logic us);
        logic mis, al, pr;
        mis = (sz == 2'd1) ? lo[0] : (sz == 2'd2) ? (lo[1:0] != 0) :
              (sz == 2'd3) ? (lo != 0) : 1'b0;
        al = am && ac && pl == 2'd3 && (pm || vm) && mis;
        if (pl == 2'd3) pr = !us || (wr && !rw);
        else            pr = wp && wr && !rw;
        return pr ? 2'b10 : (al ? 2'b01 : 2'b00);
    endfunction

    task automatic access(input logic am, input logic wp, input logic ac, input logic [1:0] pl,
            input logic pm, input logic vm, input logic [AW-1:0] ad, input logic [1:0] sz,
            input logic wr, input logic rw, input logic us, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1;
        ctrl_word = 32'h8000_0011 | ({31'd0, am} << 18) | ({31'd0, wp} << 16);
        flag_align_chk = ac; cur_priv = pl; prot_mode = pm; v86_mode = vm;
        acc_addr = ad; acc_size = sz; acc_write = wr; page_writable = rw; page_user = us;
        e.vld = 1'b1;
        e.code = model(am, wp, ac, pl, pm, vm, ad[2:0], sz, wr, rw, us);
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic idle(input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = 1'b0;
        ctrl_word = 32'hFFFF_FFFF;
        cur_priv = 2'd3; page_user = 1'b0;
        e.vld = 1'b0; e.code = 2'b00; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: one expected entry per cycle, sampled after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                logic [1:0] flags;
                e = sb.pop_front();
                flags = {fault_prot, fault_align};
                n_checks++;
                if (verdict_valid !== e.vld || fault_code !== e.code || flags !== e.code) begin
                    n_fail++;
                    $display("FAIL %s: valid=%0b code=%02b flags=%02b expected valid=%0b code=%02b",
                             e.tag, verdict_valid, fault_code, flags, e.vld, e.code);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        n_checks++;
        // R9: reset state
        if (verdict_valid !== 1'b0 || fault_code !== 2'b00 || fault_align !== 1'b0 || fault_prot !== 1'b0) begin
            n_fail++;
            $display("FAIL R9: valid=%0b code=%02b expected 0 00", verdict_valid, fault_code);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1: armed alignment faults, both modes
        access(1, 0, 1, 3, 1, 0, 32'h1001, 1, 0, 1, 1, "R1");
        access(1, 0, 1, 3, 0, 1, 32'h1002, 2, 1, 1, 1, "R1");
        access(1, 0, 1, 3, 0, 0, 32'h1002, 2, 0, 1, 1, "R1");
        access(1, 0, 0, 3, 1, 0, 32'h1002, 2, 0, 1, 1, "R1");
        access(1, 0, 1, 2, 1, 0, 32'h1002, 2, 0, 1, 1, "R1");

        // R2: mask clear suppresses alignment under all other inputs
        for (int i = 0; i < 32; i++)
            access(0, i[4], 1, 3, i[0], i[1], {29'd0, i[2], i[3], 1'b1}, 3, i[4], 1, 1, "R2");

        // R3: every size against every low address
        for (int s = 0; s < 4; s++)
            for (int a = 0; a < 8; a++)
                access(1, 0, 1, 3, 1, 0, 32'hABC0 + a, s[1:0], 0, 1, 1, "R3");

        // R4, R5, R6: privilege x write-protect x direction x page bits
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 16; k++)
                access(0, k[0], 0, p[1:0], 1, 0, 32'h2000, 2, k[1], k[2], k[3],
                       (p == 3) ? "R6" : (k[0] ? "R4" : "R5"));

        // R7: both faults at once, protection wins
        access(1, 1, 1, 3, 1, 0, 32'h3003, 2, 0, 1, 0, "R7");
        access(1, 0, 1, 3, 0, 1, 32'h3001, 1, 1, 0, 1, "R7");

        // R8: idle cycles return to quiet, including between faults
        access(1, 0, 1, 3, 1, 0, 32'h4001, 3, 0, 1, 0, "R8");
        idle("R8");
        idle("R8");
        access(1, 0, 1, 3, 1, 0, 32'h4004, 3, 0, 1, 1, "R8");
        idle("R8");
        idle("R8");

        repeat (3) @(posedge clk);
        #3;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule